// File: doc/BRIEF.md
# Carry-Chained Integer Add/Subtract Unit

This block is the add/subtract slice of a fixed-point execution pipe. Each issued operation takes a first register operand, a second register operand, a short signed immediate and an operation code. It forms one two-operand sum with a selectable carry-in and writes the result. It also keeps the carry and overflow status that later extended operations read. Every subtraction is built as the complement of the first operand plus the second operand plus a carry, so one adder serves all sixteen operations.

The adder is split at its midpoint. The lower half yields the half-width carry and half-width overflow, and the upper half yields the full-width ones. Both sets of flags therefore come from the same sum. The status bits (carry, half carry, overflow, half overflow, sticky summary overflow) and a four-bit record field live in registers inside the block. The overflow-enable and record-enable controls arrive as plain inputs next to the operation code. Results and flags appear one clock after an issue.

Top module: `carry_addsub_unit`

## Requirements
- R1: While reset is held and after it is released with no issue, the result, every status bit and the record field read zero.
- R2: Plain add, add-carrying and add-immediate-carrying write A+B, A+B and A+sext(imm) respectively, modulo 2^XLEN.
- R3: Subtract-from, subtract-from-carrying and subtract-from-immediate-carrying write ~A+B+1 (and ~A+sext(imm)+1); negate writes ~A+1.
- R4: Add-extended writes A+B+CA and subtract-extended writes ~A+B+CA, where CA is the stored carry from earlier operations.
- R5: Minus-one-extended writes A+CA-1 (the second operand is all ones); zero-extended writes A+CA; the subtract versions use ~A in place of A.
- R6: Add-immediate writes A+sext(imm). Add-immediate-shifted places imm at bits [2*IMM_W-1:IMM_W], zeroes the bits below and sign-extends. For both, an asserted ra_is_zero replaces A with zero.
- R7: CA takes the carry out of the top bit and CA_HALF the carry out of bit XLEN/2-1 of the same sum. Only the carrying, immediate-carrying and extended operations write them; all other operations leave both unchanged.
- R8: With ov_en set, the register forms (add, subtract-from, their carrying and extended variants, negate) write OV as the signed XLEN-bit overflow and OV_HALF as the signed XLEN/2-bit overflow of the low halves. With ov_en clear, and for the immediate forms regardless of ov_en, OV and OV_HALF hold.
- R9: SO is ORed with each newly written OV and clears only on reset.
- R10: Alternate-carry add writes A+B+OV and stores the full and half carry outs into OV and OV_HALF; CA, CA_HALF and SO stay unchanged; ov_en has no effect on it.
- R11: With rec_en set, the record field takes bit 3 = result negative, bit 2 = result positive (nonzero, sign clear), bit 1 = result zero, bit 0 = SO after this operation. With rec_en clear it holds.
- R12: A cycle with op_valid low changes neither the result, the status bits nor the record field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issue strobe; clock enable for all state |
| op_sel | input | 4 | Operation code (package enumeration) |
| opnd_a | input | XLEN | First register operand |
| opnd_b | input | XLEN | Second register operand |
| imm | input | IMM_W | Signed immediate |
| ra_is_zero | input | 1 | Register selector is zero (immediate add forms) |
| ov_en | input | 1 | Overflow-enable for register forms |
| rec_en | input | 1 | Record-enable |
| result | output | XLEN | Registered result |
| ca | output | 1 | Carry out of the top bit |
| ca_half | output | 1 | Carry out of the lower half |
| ov | output | 1 | Signed overflow, full width |
| ov_half | output | 1 | Signed overflow, lower half |
| so | output | 1 | Sticky summary overflow |
| rec_field | output | 4 | Negative, positive, zero, SO |

## Verification
The assertions take op_sel to hold one of the sixteen defined codes and the controls to be known at every clock edge after reset. They also take rec_field and the status bits to be reached only through issued operations. The stimulus holds to this by drawing op_sel only from the enumeration and driving every input on the falling edge. It runs a corner sweep at a small width, XLEN=24 and IMM_W=8, where carries out of the middle and top bits and signed limits are easy to hit. A long run of random operations with idle cycles mixed in follows the sweep.

// File: rtl/arith_unit_pkg.sv
package arith_unit_pkg;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUBF, OP_ADDI, OP_ADDIS, OP_ADDIC, OP_SUBFIC, OP_ADDC, OP_SUBFC,
    OP_ADDE, OP_SUBFE, OP_ADDME, OP_SUBFME, OP_ADDZE, OP_SUBFZE, OP_NEG, OP_ADDEX
  } op_e;

  typedef enum logic [2:0] {BS_REG, BS_IMM, BS_IMM_HI, BS_ONES, BS_ZERO} bsel_e;
  typedef enum logic [1:0] {CS_ZERO, CS_ONE, CS_CA, CS_OV} csel_e;

  typedef struct packed {
    logic  inv_a;      // first operand complemented
    bsel_e bsel;       // second operand source
    csel_e csel;       // carry-in source
    logic  zero_a_ok;  // selector-zero may null the first operand
    logic  ca_wr;      // writes CA / CA_HALF
    logic  ov_ok;      // OV / OV_HALF / SO written when enabled
    logic  ov_carry;   // carry outs written to OV / OV_HALF
  } ctl_t;

  function automatic ctl_t decode_op(op_e op);
    ctl_t c;
    c = '{inv_a: 1'b0, bsel: BS_REG, csel: CS_ZERO, zero_a_ok: 1'b0,
          ca_wr: 1'b0, ov_ok: 1'b0, ov_carry: 1'b0};
    case (op)
      OP_ADD:    begin c.ov_ok = 1'b1; end
      OP_SUBF:   begin c.inv_a = 1'b1; c.csel = CS_ONE; c.ov_ok = 1'b1; end
      OP_ADDI:   begin c.bsel = BS_IMM; c.zero_a_ok = 1'b1; end
      OP_ADDIS:  begin c.bsel = BS_IMM_HI; c.zero_a_ok = 1'b1; end
      OP_ADDIC:  begin c.bsel = BS_IMM; c.ca_wr = 1'b1; end
      OP_SUBFIC: begin c.inv_a = 1'b1; c.bsel = BS_IMM; c.csel = CS_ONE; c.ca_wr = 1'b1; end
      OP_ADDC:   begin c.ca_wr = 1'b1; c.ov_ok = 1'b1; end
      OP_SUBFC:  begin c.inv_a = 1'b1; c.csel = CS_ONE; c.ca_wr = 1'b1; c.ov_ok = 1'b1; end
      OP_ADDE:   begin c.csel = CS_CA; c.ca_wr = 1'b1; c.ov_ok = 1'b1; end
      OP_SUBFE:  begin c.inv_a = 1'b1; c.csel = CS_CA; c.ca_wr = 1'b1; c.ov_ok = 1'b1; end
      OP_ADDME:  begin c.bsel = BS_ONES; c.csel = CS_CA; c.ca_wr = 1'b1; c.ov_ok = 1'b1; end
      OP_SUBFME: begin c.inv_a = 1'b1; c.bsel = BS_ONES; c.csel = CS_CA; c.ca_wr = 1'b1; c.ov_ok = 1'b1; end
      OP_ADDZE:  begin c.bsel = BS_ZERO; c.csel = CS_CA; c.ca_wr = 1'b1; c.ov_ok = 1'b1; end
      OP_SUBFZE: begin c.inv_a = 1'b1; c.bsel = BS_ZERO; c.csel = CS_CA; c.ca_wr = 1'b1; c.ov_ok = 1'b1; end
      OP_NEG:    begin c.inv_a = 1'b1; c.bsel = BS_ZERO; c.csel = CS_ONE; c.ov_ok = 1'b1; end
      OP_ADDEX:  begin c.csel = CS_OV; c.ov_carry = 1'b1; end
      default:   ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/opnd_select.sv
module opnd_select
  import arith_unit_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input  ctl_t              ctl,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              ra_is_zero,
  input  logic              ca_q,
  input  logic              ov_q,
  output logic [XLEN-1:0]   x_op,
  output logic [XLEN-1:0]   y_op,
  output logic              c_in
);
  localparam int LO_EXT = XLEN - IMM_W;
  localparam int HI_EXT = XLEN - 2 * IMM_W;

  logic [XLEN-1:0] imm_lo;
  logic [XLEN-1:0] imm_hi;
  logic [XLEN-1:0] a_base;

  assign imm_lo = {{LO_EXT{imm[IMM_W-1]}}, imm};

  generate
    if (HI_EXT > 0) begin : g_hi_ext
      assign imm_hi = {{HI_EXT{imm[IMM_W-1]}}, imm, {IMM_W{1'b0}}};
    end else begin : g_hi_fit
      assign imm_hi = {imm, {IMM_W{1'b0}}};
    end
  endgenerate

  assign a_base = (ctl.zero_a_ok && ra_is_zero) ? '0 : opnd_a;

  always_comb begin
    x_op = ctl.inv_a ? ~a_base : a_base;
    case (ctl.bsel)
      BS_REG:    y_op = opnd_b;
      BS_IMM:    y_op = imm_lo;
      BS_IMM_HI: y_op = imm_hi;
      BS_ONES:   y_op = '1;
      default:   y_op = '0;
    endcase
    case (ctl.csel)
      CS_ONE:  c_in = 1'b1;
      CS_CA:   c_in = ca_q;
      CS_OV:   c_in = ov_q;
      default: c_in = 1'b0;
    endcase
  end
endmodule

// File: rtl/split_adder.sv
module split_adder #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] x_op,
  input  logic [XLEN-1:0] y_op,
  input  logic            c_in,
  output logic [XLEN-1:0] sum,
  output logic            c_full,
  output logic            c_half,
  output logic            v_full,
  output logic            v_half
);
  localparam int HALF = XLEN / 2;
  localparam int UPW  = XLEN - HALF;

  logic [HALF:0] lo_sum;
  logic [UPW:0]  hi_sum;

  always_comb begin
    lo_sum = {1'b0, x_op[HALF-1:0]} + {1'b0, y_op[HALF-1:0]} + {{HALF{1'b0}}, c_in};
    hi_sum = {1'b0, x_op[XLEN-1:HALF]} + {1'b0, y_op[XLEN-1:HALF]} + {{UPW{1'b0}}, lo_sum[HALF]};
    sum    = {hi_sum[UPW-1:0], lo_sum[HALF-1:0]};
    c_half = lo_sum[HALF];
    c_full = hi_sum[UPW];
    // signed overflow: carry into the sign bit differs from carry out of it
    v_half = x_op[HALF-1] ^ y_op[HALF-1] ^ lo_sum[HALF-1] ^ c_half;
    v_full = x_op[XLEN-1] ^ y_op[XLEN-1] ^ sum[XLEN-1] ^ c_full;
  end
endmodule

// File: rtl/status_regs.sv
module status_regs
  import arith_unit_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  ctl_t            ctl,
  input  logic            ov_en,
  input  logic            rc_en,
  input  logic [XLEN-1:0] sum,
  input  logic            c_full,
  input  logic            c_half,
  input  logic            v_full,
  input  logic            v_half,
  output logic [XLEN-1:0] res_q,
  output logic            ca_q,
  output logic            ca_h_q,
  output logic            ov_q,
  output logic            ov_h_q,
  output logic            so_q,
  output logic [3:0]      rec_q
);
  logic ca_n, ca_h_n, ov_n, ov_h_n, so_n;
  logic [3:0] rec_n;
  logic neg, zero;

  always_comb begin
    ca_n   = ca_q;
    ca_h_n = ca_h_q;
    ov_n   = ov_q;
    ov_h_n = ov_h_q;
    so_n   = so_q;
    if (ctl.ca_wr) begin
      ca_n   = c_full;
      ca_h_n = c_half;
    end
    if (ctl.ov_carry) begin
      ov_n   = c_full;
      ov_h_n = c_half;
    end else if (ctl.ov_ok && ov_en) begin
      ov_n   = v_full;
      ov_h_n = v_half;
      so_n   = so_q | v_full;
    end
    neg   = sum[XLEN-1];
    zero  = (sum == '0);
    rec_n = {neg, ~neg & ~zero, zero, so_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      ca_q   <= 1'b0;
      ca_h_q <= 1'b0;
      ov_q   <= 1'b0;
      ov_h_q <= 1'b0;
      so_q   <= 1'b0;
    end else if (en) begin
      res_q  <= sum;
      ca_q   <= ca_n;
      ca_h_q <= ca_h_n;
      ov_q   <= ov_n;
      ov_h_q <= ov_h_n;
      so_q   <= so_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rec_q <= '0;
    else if (en && rc_en)  rec_q <= rec_n;
  end

  p_so_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    so_q |=> so_q);
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(res_q) && $stable({ca_q, ca_h_q, ov_q, ov_h_q, so_q}) && $stable(rec_q)));
  p_rec_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rc_en) |=> $stable(rec_q));
  p_rec_class_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rc_en) |=> ($countones(rec_q[3:1]) == 1));
  p_ca_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ctl.ca_wr) |=> $stable({ca_q, ca_h_q}));
endmodule

// File: rtl/carry_addsub_unit.sv
module carry_addsub_unit
  import arith_unit_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [3:0]       op_sel,
  input  logic [XLEN-1:0]  opnd_a,
  input  logic [XLEN-1:0]  opnd_b,
  input  logic [IMM_W-1:0] imm,
  input  logic             ra_is_zero,
  input  logic             ov_en,
  input  logic             rec_en,
  output logic [XLEN-1:0]  result,
  output logic             ca,
  output logic             ca_half,
  output logic             ov,
  output logic             ov_half,
  output logic             so,
  output logic [3:0]       rec_field
);
  op_e             op;
  ctl_t            ctl;
  logic [XLEN-1:0] x_op, y_op, sum;
  logic            c_in, c_full, c_half, v_full, v_half;

  assign op  = op_e'(op_sel);
  assign ctl = decode_op(op);

  opnd_select #(.XLEN(XLEN), .IMM_W(IMM_W)) u_sel (
    .ctl(ctl), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm),
    .ra_is_zero(ra_is_zero), .ca_q(ca), .ov_q(ov),
    .x_op(x_op), .y_op(y_op), .c_in(c_in)
  );

  split_adder #(.XLEN(XLEN)) u_add (
    .x_op(x_op), .y_op(y_op), .c_in(c_in), .sum(sum),
    .c_full(c_full), .c_half(c_half), .v_full(v_full), .v_half(v_half)
  );

  status_regs #(.XLEN(XLEN)) u_stat (
    .clk(clk), .rst_n(rst_n), .en(op_valid), .ctl(ctl),
    .ov_en(ov_en), .rc_en(rec_en), .sum(sum),
    .c_full(c_full), .c_half(c_half), .v_full(v_full), .v_half(v_half),
    .res_q(result), .ca_q(ca), .ca_h_q(ca_half), .ov_q(ov),
    .ov_h_q(ov_half), .so_q(so), .rec_q(rec_field)
  );

  p_addex_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_ADDEX) |=> ($stable(ca) && $stable(ca_half) && $stable(so)));
endmodule

// File: tb/carry_addsub_unit_tb_top.sv
module carry_addsub_unit_tb_top;
  import arith_unit_pkg::*;

  localparam int W = 24;
  localparam int H = W / 2;
  localparam int IW = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic op_valid, ra_is_zero, ov_en, rec_en;
  logic [3:0] op_sel;
  logic [W-1:0] opnd_a, opnd_b;
  logic [IW-1:0] imm;
  logic [W-1:0] result;
  logic ca, ca_half, ov, ov_half, so;
  logic [3:0] rec_field;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [W-1:0] m_res;
  bit m_ca, m_cah, m_ov, m_ovh, m_so;
  logic [3:0] m_rec;

  always #(CLK_PERIOD/2) clk = ~clk;

  carry_addsub_unit #(.XLEN(W), .IMM_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .ra_is_zero(ra_is_zero),
    .ov_en(ov_en), .rec_en(rec_en), .result(result), .ca(ca), .ca_half(ca_half),
    .ov(ov), .ov_half(ov_half), .so(so), .rec_field(rec_field)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string res_tag(op_e op);
    case (op)
      OP_ADD, OP_ADDC, OP_ADDIC:             return "R2 result";
      OP_SUBF, OP_SUBFC, OP_SUBFIC, OP_NEG:  return "R3 result";
      OP_ADDE, OP_SUBFE:                     return "R4 result";
      OP_ADDME, OP_SUBFME, OP_ADDZE, OP_SUBFZE: return "R5 result";
      OP_ADDI, OP_ADDIS:                     return "R6 result";
      default:                               return "R10 result";
    endcase
  endfunction

  task automatic step(input bit v, input op_e op, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic [IW-1:0] im,
                      input bit raz, input bit oe, input bit rc);
    logic [W-1:0] x, y, base;
    logic [W:0] full;
    logic [H:0] low;
    bit cin, vf, vh, cw, ook, addex;
    int sx, sh;
    @(negedge clk);
    op_valid = v; op_sel = op; opnd_a = a; opnd_b = b; imm = im;
    ra_is_zero = raz; ov_en = oe; rec_en = rc;
    if (v) begin
      base = ((op == OP_ADDI || op == OP_ADDIS) && raz) ? '0 : a;
      x = base; y = b; cin = 1'b0; cw = 1'b0; ook = 1'b1; addex = 1'b0;
      case (op)
        OP_ADD:    ;
        OP_SUBF:   begin x = ~a; cin = 1; end
        OP_ADDI:   begin y = W'($signed(im)); ook = 0; end
        OP_ADDIS:  begin y = W'($signed({im, 8'h00})); ook = 0; end
        OP_ADDIC:  begin y = W'($signed(im)); cw = 1; ook = 0; end
        OP_SUBFIC: begin x = ~a; y = W'($signed(im)); cin = 1; cw = 1; ook = 0; end
        OP_ADDC:   cw = 1;
        OP_SUBFC:  begin x = ~a; cin = 1; cw = 1; end
        OP_ADDE:   begin cin = m_ca; cw = 1; end
        OP_SUBFE:  begin x = ~a; cin = m_ca; cw = 1; end
        OP_ADDME:  begin y = '1; cin = m_ca; cw = 1; end
        OP_SUBFME: begin x = ~a; y = '1; cin = m_ca; cw = 1; end
        OP_ADDZE:  begin y = '0; cin = m_ca; cw = 1; end
        OP_SUBFZE: begin x = ~a; y = '0; cin = m_ca; cw = 1; end
        OP_NEG:    begin x = ~a; y = '0; cin = 1; end
        default:   begin cin = m_ov; ook = 0; addex = 1; end
      endcase
      full = {1'b0, x} + {1'b0, y} + (W+1)'(cin);
      low  = {1'b0, x[H-1:0]} + {1'b0, y[H-1:0]} + (H+1)'(cin);
      sx = $signed(x) + $signed(y) + int'(cin);
      sh = $signed(x[H-1:0]) + $signed(y[H-1:0]) + int'(cin);
      vf = (sx > (1 << (W-1)) - 1) || (sx < -(1 << (W-1)));
      vh = (sh > (1 << (H-1)) - 1) || (sh < -(1 << (H-1)));
      m_res = full[W-1:0];
      if (cw) begin m_ca = full[W]; m_cah = low[H]; end
      if (addex) begin m_ov = full[W]; m_ovh = low[H]; end
      else if (ook && oe) begin m_ov = vf; m_ovh = vh; m_so = m_so | vf; end
      if (rc) m_rec = {m_res[W-1], !m_res[W-1] && m_res != 0, m_res == 0, m_so};
    end
    @(posedge clk);
    #1;
    chk(v ? res_tag(op) : "R12 result idle", 32'(result), 32'(m_res));
    chk(v ? "R7 ca" : "R12 ca idle", 32'(ca), 32'(m_ca));
    chk(v ? "R7 ca_half" : "R12 ca_half idle", 32'(ca_half), 32'(m_cah));
    chk(addex ? "R10 ov" : "R8 ov", 32'(ov), 32'(m_ov));
    chk(addex ? "R10 ov_half" : "R8 ov_half", 32'(ov_half), 32'(m_ovh));
    chk("R9 so", 32'(so), 32'(m_so));
    chk("R11 rec_field", 32'(rec_field), 32'(m_rec));
  endtask

  initial begin
    logic [W-1:0] corners [8];
    corners[0] = 24'h000000; corners[1] = 24'h000001; corners[2] = 24'hFFFFFF;
    corners[3] = 24'h7FFFFF; corners[4] = 24'h800000; corners[5] = 24'h000FFF;
    corners[6] = 24'h0007FF; corners[7] = 24'h555AAA;
    rst_n = 1'b0; op_valid = 0; op_sel = '0; opnd_a = '0; opnd_b = '0;
    imm = '0; ra_is_zero = 0; ov_en = 0; rec_en = 0;
    m_res = '0; m_ca = 0; m_cah = 0; m_ov = 0; m_ovh = 0; m_so = 0; m_rec = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset result", 32'(result), 0);
    chk("R1 reset flags", 32'({ca, ca_half, ov, ov_half, so}), 0);
    chk("R1 reset rec", 32'(rec_field), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after release", 32'({result, ca, ca_half, ov, ov_half, so, rec_field}), 0);

    for (int o = 0; o < 16; o++)
      for (int ai = 0; ai < 8; ai++)
        for (int bi = 0; bi < 8; bi++)
          for (int e = 0; e < 2; e++)
            step(1'b1, op_e'(o), corners[ai], corners[bi], corners[bi][IW-1:0] ^ 8'(ai << 5),
                 bi[0], e[0], (ai + bi + e) % 3 != 0);

    for (int i = 0; i < 20000; i++)
      step(($urandom % 4) != 0, op_e'($urandom % 16), W'($urandom), W'($urandom),
           IW'($urandom), $urandom % 2, $urandom % 2, $urandom % 2);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule